// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the hazard controller for a five-stage in-order pipeline. The stages, in order, are instruction fetch, decode, operand fetch, execute and result write. Every cycle the datapath reports each stage's occupancy, whether operand fetch needs the shared memory port, whether decode holds a branch, and whether execute has resolved a branch and its outcome. The block also sees execute's destination register and the source registers of the instruction in operand fetch. It answers in the same cycle with a fetch hold, a per-stage bubble vector, per-source forwarding selects and a fetch-redirect strobe that says whether the new address is the branch target or the fall-through address.

Three static branch policies can be chosen at run time: freeze, predict-untaken and predict-taken. The policy input is captured at reset and whenever the pipeline is empty. This means a policy change never takes effect in the middle of a branch. Instructions and data share one memory port, so an operand-fetch read forces fetch to wait one cycle. The empty slot this leaves behind travels down the pipe as a bubble.

Top module: `hz_ctrl`

## Requirements
- R1: After reset, with all inputs low, fetch_hold_o, flush_o, redirect_o, redirect_tgt_o and fwd_sel_o are all 0.
- R2: With no hazard inputs active, no control output is asserted, so a simple shifting pipeline retires n instructions in n+4 cycles.
- R3: When stage_vld_i[2] and of_mem_rd_i are both 1 and no redirect is issued, fetch_hold_o is 1 and flush_o is 5'b00010 (decode loads a bubble; operand fetch, execute and write are not flushed). If stage_vld_i[2] is 0, a memory read request has no effect.
- R4: fwd_sel_o[i] is 1 exactly when stage_vld_i[2], stage_vld_i[3] and ex_wr_en_i are all 1, ex_dst_i is non-zero, and ex_dst_i equals of_src_i[i].
- R5: Freeze (policy_i = 0): a valid branch in decode asserts fetch_hold_o and flush_o = 5'b00010. This continues every cycle until execute reports resolution. In the resolution cycle redirect_o = 1, redirect_tgt_o equals the branch outcome, flush_o = 5'b00010 and fetch_hold_o = 0.
- R6: Predict-untaken (policy_i = 1): decoding a branch causes no action. A branch resolved as taken gives redirect_o = 1, redirect_tgt_o = 1 and flush_o = 5'b01110. A branch resolved as not taken causes no action.
- R7: Predict-taken (policy_i = 2): decoding a branch gives redirect_o = 1, redirect_tgt_o = 1 and flush_o = 5'b00010. A branch resolved as not taken gives redirect_o = 1, redirect_tgt_o = 0 and flush_o = 5'b01110. A branch resolved as taken causes no action.
- R8: A redirect overrides a fetch hold. In any cycle with redirect_o = 1, fetch_hold_o is 0, even if there is a memory port conflict.
- R9: The policy is captured during reset, and on any clock edge where stage_vld_i is 0 and no freeze wait is pending. A policy_i change at any other time has no effect. policy_i = 3 acts as freeze.
- R10: Under predict-taken, a not-taken resolution in execute takes priority over a branch decoded in the same cycle: redirect_tgt_o = 0 and flush_o = 5'b01110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_i | input | 2 | Branch policy: 0 freeze, 1 predict-untaken, 2 predict-taken, 3 freeze |
| stage_vld_i | input | 5 | Occupancy per stage; bit 0 fetch through bit 4 write |
| of_mem_rd_i | input | 1 | Operand-fetch instruction needs the shared memory port |
| id_is_br_i | input | 1 | Decode holds a branch with its target computed |
| ex_br_done_i | input | 1 | Execute resolves a branch this cycle |
| ex_br_taken_i | input | 1 | Outcome of the branch resolved in execute |
| ex_wr_en_i | input | 1 | Execute instruction writes a register |
| ex_dst_i | input | REG_W | Destination register of execute |
| of_src_i | input | NSRC x REG_W | Source registers of operand fetch |
| fetch_hold_o | output | 1 | Fetch keeps its PC and instruction |
| flush_o | output | 5 | Bit k: stage k register loads a bubble at the next edge |
| redirect_o | output | 1 | Fetch loads a new address |
| redirect_tgt_o | output | 1 | 1: branch target, 0: fall-through (0 when no redirect) |
| fwd_sel_o | output | NSRC | Per source: take the execute result instead of the register value |

## Verification
The bench first streams hazard-free occupancy through a shifting model of the pipeline, which shows that the controller adds no cycles. It then drives each policy with taken and not-taken outcomes. This separates redirects at decode from redirects at execute, and target addresses from fall-through addresses. Forwarding is tried with a match on each source, on both sources, on register 0, with writing disabled, and with execute empty, which isolates every term of the compare. Collisions are driven as well: a memory conflict in the same cycle as a redirect, a decode and a resolve arriving together, and policy changes made while the pipe is busy and while it is idle. These show that priority and the sampling of the policy both behave as required.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int NSTG   = 5;
    localparam int STG_IF = 0;
    localparam int STG_ID = 1;
    localparam int STG_OF = 2;
    localparam int STG_EX = 3;
    localparam int STG_WO = 4;

    localparam logic [NSTG-1:0] FL_ID    = NSTG'(1) << STG_ID;
    localparam logic [NSTG-1:0] FL_YOUNG = (NSTG'(1) << STG_ID) |
                                           (NSTG'(1) << STG_OF) |
                                           (NSTG'(1) << STG_EX);

    typedef enum logic [1:0] {
        POL_FREEZE  = 2'd0,
        POL_UNTAKEN = 2'd1,
        POL_TAKEN   = 2'd2
    } pol_e;

    typedef struct packed {
        pol_e pol;
        logic pend;
    } br_st_t;

    function automatic pol_e map_pol(input logic [1:0] raw);
        case (raw)
            2'd1:    map_pol = POL_UNTAKEN;
            2'd2:    map_pol = POL_TAKEN;
            default: map_pol = POL_FREEZE;
        endcase
    endfunction

endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       of_vld_i,
    input  logic                       ex_vld_i,
    input  logic                       ex_wr_i,
    input  logic [REG_W-1:0]           ex_dst_i,
    input  logic [NSRC-1:0][REG_W-1:0] src_i,
    output logic [NSRC-1:0]            fwd_o
);

    logic ex_live;

    always_comb begin
        ex_live = of_vld_i && ex_vld_i && ex_wr_i && (ex_dst_i != '0);
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_comb begin
            fwd_o[i] = ex_live && (ex_dst_i == src_i[i]);
        end

        // R4
        fwd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_o[i] |-> (src_i[i] != '0) && ex_vld_i && of_vld_i);
    end

endmodule

// File: rtl/hz_branch_ctl.sv
module hz_branch_ctl
    import hz_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      pol_raw_i,
    input  logic            pipe_empty_i,
    input  logic            id_br_i,
    input  logic            ex_res_i,
    input  logic            ex_tkn_i,
    output logic            redirect_o,
    output logic            redir_tgt_o,
    output logic            br_hold_o,
    output logic [NSTG-1:0] br_flush_o
);

    br_st_t st_d, st_q;
    logic   idle;

    always_comb begin
        st_d        = st_q;
        redirect_o  = 1'b0;
        redir_tgt_o = 1'b0;
        br_hold_o   = 1'b0;
        br_flush_o  = '0;
        idle        = pipe_empty_i && !st_q.pend;

        if (idle) begin
            st_d.pol = map_pol(pol_raw_i);
        end

        case (st_q.pol)
            POL_FREEZE: begin
                if (ex_res_i) begin
                    redirect_o  = 1'b1;
                    redir_tgt_o = ex_tkn_i;
                    br_flush_o  = FL_ID;
                    st_d.pend   = 1'b0;
                end else if (st_q.pend || id_br_i) begin
                    br_hold_o   = 1'b1;
                    br_flush_o  = FL_ID;
                    st_d.pend   = 1'b1;
                end
            end
            POL_UNTAKEN: begin
                if (ex_res_i && ex_tkn_i) begin
                    redirect_o  = 1'b1;
                    redir_tgt_o = 1'b1;
                    br_flush_o  = FL_YOUNG;
                end
            end
            POL_TAKEN: begin
                if (ex_res_i && !ex_tkn_i) begin
                    redirect_o  = 1'b1;
                    redir_tgt_o = 1'b0;
                    br_flush_o  = FL_YOUNG;
                end else if (id_br_i) begin
                    redirect_o  = 1'b1;
                    redir_tgt_o = 1'b1;
                    br_flush_o  = FL_ID;
                end
            end
            default: begin
                st_d.pend = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pol  <= map_pol(pol_raw_i);
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    policy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pipe_empty_i && !st_q.pend) |=> $stable(st_q.pol));

    // R5
    freeze_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !ex_res_i) |-> br_hold_o && !redirect_o);

    // R6
    redirect_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> br_flush_o[STG_ID] && !br_hold_o);

endmodule

// File: rtl/hz_fetch_arb.sv
module hz_fetch_arb
    import hz_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            of_vld_i,
    input  logic            of_mem_rd_i,
    input  logic            br_hold_i,
    input  logic [NSTG-1:0] br_flush_i,
    input  logic            redirect_i,
    output logic            fetch_hold_o,
    output logic [NSTG-1:0] flush_o
);

    logic port_clash;

    always_comb begin
        port_clash   = of_vld_i && of_mem_rd_i;
        fetch_hold_o = (port_clash || br_hold_i) && !redirect_i;
        flush_o      = br_flush_i;
        if (port_clash) begin
            flush_o = flush_o | FL_ID;
        end
    end

    // R3
    port_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (of_vld_i && of_mem_rd_i && !redirect_i) |-> fetch_hold_o && flush_o[STG_ID]);

    // R8
    redirect_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |-> !fetch_hold_o);

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 policy_i,
    input  logic [NSTG-1:0]            stage_vld_i,
    input  logic                       of_mem_rd_i,
    input  logic                       id_is_br_i,
    input  logic                       ex_br_done_i,
    input  logic                       ex_br_taken_i,
    input  logic                       ex_wr_en_i,
    input  logic [REG_W-1:0]           ex_dst_i,
    input  logic [NSRC-1:0][REG_W-1:0] of_src_i,
    output logic                       fetch_hold_o,
    output logic [NSTG-1:0]            flush_o,
    output logic                       redirect_o,
    output logic                       redirect_tgt_o,
    output logic [NSRC-1:0]            fwd_sel_o
);

    logic            pipe_empty;
    logic            id_br;
    logic            ex_res;
    logic            br_hold;
    logic [NSTG-1:0] br_flush;

    always_comb begin
        pipe_empty = (stage_vld_i == '0);
        id_br      = stage_vld_i[STG_ID] && id_is_br_i;
        ex_res     = stage_vld_i[STG_EX] && ex_br_done_i;
    end

    hz_branch_ctl u_branch (
        .clk          (clk),
        .rst_n        (rst_n),
        .pol_raw_i    (policy_i),
        .pipe_empty_i (pipe_empty),
        .id_br_i      (id_br),
        .ex_res_i     (ex_res),
        .ex_tkn_i     (ex_br_taken_i),
        .redirect_o   (redirect_o),
        .redir_tgt_o  (redirect_tgt_o),
        .br_hold_o    (br_hold),
        .br_flush_o   (br_flush)
    );

    hz_fetch_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .of_vld_i     (stage_vld_i[STG_OF]),
        .of_mem_rd_i  (of_mem_rd_i),
        .br_hold_i    (br_hold),
        .br_flush_i   (br_flush),
        .redirect_i   (redirect_o),
        .fetch_hold_o (fetch_hold_o),
        .flush_o      (flush_o)
    );

    hz_fwd_unit #(.REG_W(REG_W), .NSRC(NSRC)) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .of_vld_i (stage_vld_i[STG_OF]),
        .ex_vld_i (stage_vld_i[STG_EX]),
        .ex_wr_i  (ex_wr_en_i),
        .ex_dst_i (ex_dst_i),
        .src_i    (of_src_i),
        .fwd_o    (fwd_sel_o)
    );

    // R1
    quiet_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_o[STG_IF] && !flush_o[STG_WO]);

endmodule

// File: tb/tb_hz_ctrl.sv
`timescale 1ns/1ps
module tb_hz_ctrl;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       policy_i = 2'd0;
    logic [4:0]       stage_vld_i = '0;
    logic             of_mem_rd_i = 1'b0;
    logic             id_is_br_i = 1'b0;
    logic             ex_br_done_i = 1'b0;
    logic             ex_br_taken_i = 1'b0;
    logic             ex_wr_en_i = 1'b0;
    logic [4:0]       ex_dst_i = '0;
    logic [1:0][4:0]  of_src_i = '0;
    logic             fetch_hold_o;
    logic [4:0]       flush_o;
    logic             redirect_o;
    logic             redirect_tgt_o;
    logic [1:0]       fwd_sel_o;

    always #2.5 clk = ~clk;

    hz_ctrl #(.REG_W(5), .NSRC(2)) dut (
        .clk(clk), .rst_n(rst_n), .policy_i(policy_i), .stage_vld_i(stage_vld_i),
        .of_mem_rd_i(of_mem_rd_i), .id_is_br_i(id_is_br_i), .ex_br_done_i(ex_br_done_i),
        .ex_br_taken_i(ex_br_taken_i), .ex_wr_en_i(ex_wr_en_i), .ex_dst_i(ex_dst_i),
        .of_src_i(of_src_i), .fetch_hold_o(fetch_hold_o), .flush_o(flush_o),
        .redirect_o(redirect_o), .redirect_tgt_o(redirect_tgt_o), .fwd_sel_o(fwd_sel_o)
    );

    typedef struct {
        logic [9:0] val;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    // monitor: pops the item pushed for this cycle and compares
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            n_chk++;
            if ({fetch_hold_o, flush_o, redirect_o, redirect_tgt_o, fwd_sel_o} !== cur.val) begin
                n_fail++;
                $display("FAIL %s: got hold/flush/red/tgt/fwd=%b expected %b", cur.req,
                         {fetch_hold_o, flush_o, redirect_o, redirect_tgt_o, fwd_sel_o}, cur.val);
            end
        end
    end

    task automatic step(input logic [4:0] vld, input logic mrd, input logic dec,
                        input logic res, input logic tkn, input logic wr,
                        input logic [4:0] dst, input logic [4:0] s0, input logic [4:0] s1,
                        input logic e_hold, input logic [4:0] e_fl, input logic e_red,
                        input logic e_tgt, input logic [1:0] e_fwd, input string req);
        exp_t e;
        @(negedge clk);
        #1;
        stage_vld_i = vld; of_mem_rd_i = mrd; id_is_br_i = dec;
        ex_br_done_i = res; ex_br_taken_i = tkn; ex_wr_en_i = wr;
        ex_dst_i = dst; of_src_i[0] = s0; of_src_i[1] = s1;
        e.val = {e_hold, e_fl, e_red, e_tgt, e_fwd};
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic br(input logic [4:0] vld, input logic mrd, input logic dec,
                      input logic res, input logic tkn, input logic e_hold,
                      input logic [4:0] e_fl, input logic e_red, input logic e_tgt,
                      input string req);
        step(vld, mrd, dec, res, tkn, 1'b0, 5'd0, 5'd0, 5'd0,
             e_hold, e_fl, e_red, e_tgt, 2'b00, req);
    endtask

    task automatic do_reset(input logic [1:0] pol);
        @(negedge clk);
        #1;
        rst_n = 1'b0; policy_i = pol;
        stage_vld_i = '0; of_mem_rd_i = 0; id_is_br_i = 0; ex_br_done_i = 0;
        ex_br_taken_i = 0; ex_wr_en_i = 0; ex_dst_i = '0; of_src_i = '0;
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic fill_test(input int n);
        logic [4:0] pv = '0;
        int issued = 0;
        int retired = 0;
        int cyc = 0;
        while (retired < n && cyc < 100) begin
            pv = {pv[3:0], (issued < n)};
            issued++;
            cyc++;
            br(pv, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 1'b0, 1'b0, "R2 no-hazard controls");
            if (pv[4]) retired++;
        end
        n_chk++;
        if (cyc != n + 4) begin
            n_fail++;
            $display("FAIL R2: %0d instructions took %0d cycles, expected %0d", n, cyc, n + 4);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset(2'd0);
        // R1 reset state
        br(5'b00000, 0, 0, 0, 0, 0, 5'b00000, 0, 0, "R1 reset idle");

        // R2 fill and drain
        fill_test(6);
        fill_test(1);

        // R3 shared memory port
        br(5'b00111, 1, 0, 0, 0, 1, 5'b00010, 0, 0, "R3 port clash");
        br(5'b11011, 1, 0, 0, 0, 0, 5'b00000, 0, 0, "R3 no clash when OF empty");

        // R4 forwarding
        step(5'b01100, 0, 0, 0, 0, 1, 5'd7, 5'd7, 5'd5, 0, 5'b0, 0, 0, 2'b01, "R4 src0 match");
        step(5'b01100, 0, 0, 0, 0, 1, 5'd7, 5'd3, 5'd7, 0, 5'b0, 0, 0, 2'b10, "R4 src1 match");
        step(5'b01100, 0, 0, 0, 0, 1, 5'd9, 5'd9, 5'd9, 0, 5'b0, 0, 0, 2'b11, "R4 both match");
        step(5'b01100, 0, 0, 0, 0, 1, 5'd0, 5'd0, 5'd0, 0, 5'b0, 0, 0, 2'b00, "R4 register zero");
        step(5'b01100, 0, 0, 0, 0, 0, 5'd7, 5'd7, 5'd7, 0, 5'b0, 0, 0, 2'b00, "R4 no write");
        step(5'b00100, 0, 0, 0, 0, 1, 5'd7, 5'd7, 5'd7, 0, 5'b0, 0, 0, 2'b00, "R4 EX empty");
        step(5'b01000, 0, 0, 0, 0, 1, 5'd7, 5'd7, 5'd7, 0, 5'b0, 0, 0, 2'b00, "R4 OF empty");

        // R5 freeze, taken then untaken
        br(5'b00011, 0, 1, 0, 0, 1, 5'b00010, 0, 0, "R5 freeze decode");
        br(5'b00101, 0, 0, 0, 0, 1, 5'b00010, 0, 0, "R5 freeze wait OF");
        br(5'b01001, 0, 0, 0, 0, 1, 5'b00010, 0, 0, "R5 freeze wait EX");
        br(5'b01001, 0, 0, 1, 1, 0, 5'b00010, 1, 1, "R5 freeze resolve taken");
        br(5'b10001, 0, 0, 0, 0, 0, 5'b00000, 0, 0, "R5 freeze released");
        br(5'b00011, 0, 1, 0, 0, 1, 5'b00010, 0, 0, "R5 freeze decode 2");
        br(5'b01001, 0, 0, 1, 0, 0, 5'b00010, 1, 0, "R5 freeze resolve untaken");
        // R8 redirect beats port clash under freeze
        br(5'b00111, 1, 0, 0, 0, 1, 5'b00010, 0, 0, "R3 clash after freeze");
        br(5'b01111, 1, 0, 1, 1, 0, 5'b00010, 1, 1, "R8 freeze redirect over clash");

        // R9 policy change ignored while busy, taken while idle
        br(5'b00011, 0, 0, 0, 0, 0, 5'b00000, 0, 0, "R9 busy");
        @(negedge clk); #1; policy_i = 2'd2;
        br(5'b00011, 0, 1, 0, 0, 1, 5'b00010, 0, 0, "R9 busy change ignored");
        br(5'b01000, 0, 0, 1, 0, 0, 5'b00010, 1, 0, "R9 clear freeze wait");
        br(5'b00000, 0, 0, 0, 0, 0, 5'b00000, 0, 0, "R9 idle sample");
        br(5'b00011, 0, 1, 0, 0, 0, 5'b00010, 1, 1, "R9 new policy active");
        @(negedge clk); #1; policy_i = 2'd3;
        br(5'b00000, 0, 0, 0, 0, 0, 5'b00000, 0, 0, "R9 idle sample code 3");
        br(5'b00011, 0, 1, 0, 0, 1, 5'b00010, 0, 0, "R9 code 3 acts as freeze");
        br(5'b01000, 0, 0, 1, 1, 0, 5'b00010, 1, 1, "R9 code 3 resolve");

        // R6 predict-untaken
        do_reset(2'd1);
        br(5'b00011, 0, 1, 0, 0, 0, 5'b00000, 0, 0, "R6 decode no action");
        br(5'b01111, 0, 0, 1, 1, 0, 5'b01110, 1, 1, "R6 taken flush");
        br(5'b11111, 0, 0, 1, 0, 0, 5'b00000, 0, 0, "R6 untaken no action");
        br(5'b01111, 1, 0, 1, 0, 1, 5'b00010, 0, 0, "R3 clash under untaken");

        // R7 predict-taken
        do_reset(2'd2);
        br(5'b00011, 0, 1, 0, 0, 0, 5'b00010, 1, 1, "R7 decode redirect");
        br(5'b01111, 0, 0, 1, 0, 0, 5'b01110, 1, 0, "R7 mispredict flush");
        br(5'b01111, 0, 0, 1, 1, 0, 5'b00000, 0, 0, "R7 taken confirmed");
        // R10 execute beats decode
        br(5'b01011, 0, 1, 1, 0, 0, 5'b01110, 1, 0, "R10 EX over ID");
        // R8 redirect beats port clash
        br(5'b01111, 1, 0, 1, 0, 0, 5'b01110, 1, 0, "R8 redirect over clash");

        repeat (3) @(negedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule